// File: doc/BRIEF.md
# Multi-Context Latency-Hiding Issue Scheduler

This block sits in one shader core and decides which of its resident thread contexts issues to the shared arithmetic datapath each cycle. Each context owns a complete private copy of the register state, so moving between threads costs nothing: the scheduler only drives the bank select (`iss_ctx`) and never saves or restores registers. The aim is to keep the arithmetic units busy during long memory fetches. The cost is storage for extra register banks; single-thread latency does not improve.

The running context keeps issuing while it stays ready. When its instruction is a memory read, signalled by the decoder on `iss_load` in the issuing cycle, three things happen:
- The block emits a memory request in that cycle, tagged with the context number.
- It parks the context from the next cycle on.
- It moves issue to another ready context, searching round-robin from the one after the last issuer.

A parked context returns to ready when a memory response carrying its tag arrives. A context is idle after reset and becomes ready when its start input is pulsed. If no context is ready, the issue slot stays empty for that cycle.

Top module: `ctx_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it ends, every context is idle: `ctx_ready` and `ctx_stalled` are all zero and `iss_valid` and `mem_req_valid` are low, whatever `iss_load` is. Reset is synchronous and active high.
- R2: A pulse on `ctx_start[i]` while context i is idle makes it ready (`ctx_ready[i]`=1) from the next cycle. A pulse on `ctx_start[i]` while context i is ready or parked has no effect on its state.
- R3: In a cycle where `iss_valid` is high and `iss_load` is high, `mem_req_valid` is high and `mem_req_tag` equals `iss_ctx`. From the next cycle, that context reads as parked (`ctx_stalled`=1, `ctx_ready`=0) and is never selected while parked. This allows at most one outstanding read per context.
- R4: A response (`rsp_valid`=1) whose `rsp_tag` names a parked context makes that context ready from the next cycle. A response whose tag names an idle or ready context changes nothing.
- R5: If the context that issued most recently is still ready, it is selected again.
- R6: Otherwise the selected context is the first ready one in the order last+1, last+2, and so on, wrapping modulo the context count. After reset, "last" is context NCTX-1, so the search begins at context 0.
- R7: When no context is ready, `iss_valid` is low and `mem_req_valid` is low even if `iss_load` is high.
- R8: A load issued by one context and a response waking a different parked context in the same cycle both take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_start | input | NCTX | Per-context start pulse; makes an idle context ready |
| ctx_ready | output | NCTX | Context is eligible to issue |
| ctx_stalled | output | NCTX | Context is parked waiting for its read response |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_ctx | output | log2(NCTX) | Register-bank select of the issuing context (0 when not valid) |
| iss_load | input | 1 | Decoder flag: the instruction issuing this cycle is a memory read |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_tag | output | log2(NCTX) | Context id carried with the request |
| rsp_valid | input | 1 | Memory response present |
| rsp_tag | input | log2(NCTX) | Context id returned with the response |

## Verification
The two functions that can coincide are parking the running context on a read and waking a different parked context on a response. The bench provokes this with a small four-context build under phases of heavy load traffic and mixed response traffic. Responses often hit parked contexts in the same cycle the running context issues a read. In each such cycle the bench judges the full ready and parked vectors one cycle later against an arithmetic model, and checks that the next selection follows the stick-then-rotate order. It also counts these collisions and the cycles with every live context parked, and requires both counts to be non-zero.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_READY = 2'd1,
      CS_STALL = 2'd2
   } ctx_st_e;
endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
   import ctx_sched_pkg::*;
#(
   parameter int TAGW = 4,
   parameter int ID   = 0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   input  logic            issued,
   input  logic            load,
   input  logic            rsp_valid,
   input  logic [TAGW-1:0] rsp_tag,
   output logic            ready,
   output logic            stalled
);
   localparam logic [TAGW-1:0] MY_TAG = TAGW'(ID);

   ctx_st_e st_q;
   logic    rsp_hit;

   assign rsp_hit = rsp_valid && (rsp_tag == MY_TAG);

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= CS_IDLE;
      end else begin
         unique case (st_q)
            CS_IDLE:  if (start) st_q <= CS_READY;
            CS_READY: if (issued && load) st_q <= CS_STALL;
            CS_STALL: if (rsp_hit) st_q <= CS_READY;
            default:  st_q <= CS_IDLE;
         endcase
      end
   end

   assign ready   = (st_q == CS_READY);
   assign stalled = (st_q == CS_STALL);

   AST_PARK_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
      issued && load |=> stalled); // R3
   AST_NO_ISSUE_PARKED: assert property (@(posedge clk) disable iff (rst)
      stalled |-> !issued); // R3
   AST_WAKE_ON_TAG: assert property (@(posedge clk) disable iff (rst)
      stalled && rsp_hit |=> ready); // R4
   AST_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
      !stalled && !ready && !start |=> !ready && !stalled); // R4
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
   parameter int N    = 16,
   parameter int TAGW = 4
) (
   input  logic [N-1:0]    req,
   input  logic [TAGW-1:0] last,
   output logic            any,
   output logic [TAGW-1:0] sel
);
   localparam bit POW2 = ((1 << TAGW) == N);

   logic [TAGW-1:0] rot_sel;
   logic            rot_found;

   generate
      if (POW2) begin : g_wrap_trunc
         always_comb begin
            rot_sel   = '0;
            rot_found = 1'b0;
            for (int k = 1; k <= N; k++) begin
               logic [TAGW-1:0] idx;
               idx = last + TAGW'(k);
               if (!rot_found && req[idx]) begin
                  rot_sel   = idx;
                  rot_found = 1'b1;
               end
            end
         end
      end else begin : g_wrap_mod
         always_comb begin
            rot_sel   = '0;
            rot_found = 1'b0;
            for (int k = 1; k <= N; k++) begin
               int idx;
               idx = (int'(last) + k) % N;
               if (!rot_found && req[idx]) begin
                  rot_sel   = TAGW'(idx);
                  rot_found = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign any = |req;
   assign sel = req[last] ? last : rot_sel;

   AST_PICK_IS_READY: assert final (!any || req[sel]); // R6
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
   import ctx_sched_pkg::*;
#(
   parameter int NCTX = 16,
   localparam int TAGW = (NCTX > 1) ? $clog2(NCTX) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NCTX-1:0] ctx_start,
   output logic [NCTX-1:0] ctx_ready,
   output logic [NCTX-1:0] ctx_stalled,
   output logic            iss_valid,
   output logic [TAGW-1:0] iss_ctx,
   input  logic            iss_load,
   output logic            mem_req_valid,
   output logic [TAGW-1:0] mem_req_tag,
   input  logic            rsp_valid,
   input  logic [TAGW-1:0] rsp_tag
);
   generate
      if (NCTX < 2) begin : g_bad_nctx
         $error("ctx_sched needs NCTX >= 2");
      end
   endgenerate

   logic [TAGW-1:0] last_q;
   logic            pick_any;
   logic [TAGW-1:0] pick_sel;

   rr_pick #(.N(NCTX), .TAGW(TAGW)) u_pick (
      .req  (ctx_ready),
      .last (last_q),
      .any  (pick_any),
      .sel  (pick_sel)
   );

   assign iss_valid     = pick_any;
   assign iss_ctx       = pick_any ? pick_sel : '0;
   assign mem_req_valid = pick_any && iss_load;
   assign mem_req_tag   = iss_ctx;

   always_ff @(posedge clk) begin
      if (rst)            last_q <= TAGW'(NCTX - 1);
      else if (iss_valid) last_q <= iss_ctx;
   end

   generate
      for (genvar i = 0; i < NCTX; i++) begin : g_slot
         logic issued_i;
         assign issued_i = iss_valid && (iss_ctx == TAGW'(i));
         ctx_slot #(.TAGW(TAGW), .ID(i)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .start     (ctx_start[i]),
            .issued    (issued_i),
            .load      (iss_load),
            .rsp_valid (rsp_valid),
            .rsp_tag   (rsp_tag),
            .ready     (ctx_ready[i]),
            .stalled   (ctx_stalled[i])
         );
      end
   endgenerate

   AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
      ctx_ready == '0 |-> !iss_valid && !mem_req_valid); // R7
   AST_REQ_FROM_READY: assert property (@(posedge clk) disable iff (rst)
      mem_req_valid |-> ctx_ready[mem_req_tag]); // R3
   AST_STICKY_ISSUE: assert property (@(posedge clk) disable iff (rst)
      iss_valid && !iss_load |=> iss_valid && iss_ctx == $past(iss_ctx)); // R5
   AST_AFTER_RESET: assert property (@(posedge clk)
      rst |=> ctx_ready == '0 && ctx_stalled == '0); // R1
endmodule

// File: tb/sim_ctx_sched.sv
module sim_ctx_sched;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;
   localparam int TW = 2;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  ctx_start = '0;
   logic [N-1:0]  ctx_ready, ctx_stalled;
   logic          iss_valid;
   logic [TW-1:0] iss_ctx;
   logic          iss_load = 1'b0;
   logic          mem_req_valid;
   logic [TW-1:0] mem_req_tag;
   logic          rsp_valid = 1'b0;
   logic [TW-1:0] rsp_tag = '0;

   ctx_sched #(.NCTX(N)) u0 (
      .clk(clk), .rst(rst), .ctx_start(ctx_start), .ctx_ready(ctx_ready),
      .ctx_stalled(ctx_stalled), .iss_valid(iss_valid), .iss_ctx(iss_ctx),
      .iss_load(iss_load), .mem_req_valid(mem_req_valid), .mem_req_tag(mem_req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int n_r7 = 0, n_r8 = 0, n_r6 = 0;
   bit finished = 1'b0;

   int m_st[N];   // 0 idle, 1 ready, 2 parked
   int m_last;
   string st_tag;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s cycle=%0d act=%0d exp=%0d", tag, cyc, act, exp);
      end
   endtask

   function automatic int vec_of(input int code);
      int v = 0;
      for (int i = 0; i < N; i++) if (m_st[i] == code) v |= (1 << i);
      return v;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) m_st[i] = 0;
      m_last = N - 1;
      st_tag = "R1";
   endtask

   task automatic do_reset();
      rst = 1'b1; iss_load = 1'b1; ctx_start = '1; rsp_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk("R1 ready", int'(ctx_ready), 0);
      chk("R1 stalled", int'(ctx_stalled), 0);
      chk("R1 iss_valid", int'(iss_valid), 0);
      chk("R1 mem_req_valid", int'(mem_req_valid), 0);
      rst = 1'b0; ctx_start = '0; iss_load = 1'b0;
      model_reset();
      @(negedge clk);
      chk("R1 ready after", int'(ctx_ready), 0);
      chk("R1 iss_valid after", int'(iss_valid), 0);
   endtask

   task automatic step(input int ld_pct, input int rsp_pct, input int st_pct);
      int ev, ec;
      string rule;
      int hit;
      ev = 0; ec = 0; rule = "R7";
      for (int i = 0; i < N; i++) if (m_st[i] == 1) ev = 1;
      if (ev) begin
         if (m_st[m_last] == 1) begin
            ec = m_last; rule = "R5";
         end else begin
            rule = "R6";
            for (int k = N; k >= 1; k--)
               if (m_st[(m_last + k) % N] == 1) ec = (m_last + k) % N;
            n_r6++;
         end
      end else if (vec_of(2) != 0) n_r7++;
      chk({st_tag, " ready"}, int'(ctx_ready), vec_of(1));
      chk({st_tag, " stalled"}, int'(ctx_stalled), vec_of(2));
      chk({rule, " iss_valid"}, int'(iss_valid), ev);
      if (ev) chk({rule, " iss_ctx"}, int'(iss_ctx), ec);
      for (int i = 0; i < N; i++) ctx_start[i] = ($urandom_range(99) < st_pct);
      iss_load  = ($urandom_range(99) < ld_pct);
      rsp_valid = ($urandom_range(99) < rsp_pct);
      rsp_tag   = TW'($urandom_range(N - 1));
      #1;
      chk(ev ? "R3 mem_req_valid" : "R7 mem_req_valid", int'(mem_req_valid),
          (ev && iss_load) ? 1 : 0);
      if (ev && iss_load) chk("R3 mem_req_tag", int'(mem_req_tag), ec);
      hit = (rsp_valid && m_st[rsp_tag] == 2) ? 1 : 0;
      if (ev && iss_load && hit) begin st_tag = "R8"; n_r8++; end
      else if (ev && iss_load) st_tag = "R3";
      else if (rsp_valid) st_tag = "R4";
      else st_tag = "R2";
      for (int i = 0; i < N; i++) begin
         if (m_st[i] == 0 && ctx_start[i]) m_st[i] = 1;
         else if (m_st[i] == 1 && ev && ec == i && iss_load) m_st[i] = 2;
         else if (m_st[i] == 2 && hit && int'(rsp_tag) == i) m_st[i] = 1;
      end
      if (ev) m_last = ec;
      @(negedge clk);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000 && !finished) begin
            bad++;
            total++;
            $display("FAIL watchdog cycle=%0d act=1 exp=0", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      int ld[5] = '{30, 70, 90, 20, 50};
      int rp[5] = '{50, 20, 10, 80, 50};
      int sp[5] = '{30, 20, 40, 10, 50};
      model_reset();
      @(negedge clk);
      for (int p = 0; p < 5; p++) begin
         do_reset();
         for (int c = 0; c < 2000; c++) step(ld[p], rp[p], sp[p]);
      end
      chk("R7 all-parked cycles seen", int'(n_r7 > 0), 1);
      chk("R8 park and wake together seen", int'(n_r8 > 0), 1);
      chk("R6 rotation seen", int'(n_r6 > 0), 1);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule